// File: doc/BRIEF.md
# One-Time-Programmable Protection Register

This block keeps a 64-bit user segment that can be written only once, together with a small lock word. Both are meant to survive a chip reset. Software programs them through a two-write command sequence:

- The first bus write carries the setup opcode.
- The second bus write carries a word address and 16 bits of data, and starts a fixed-length program operation.

Programming can only pull bits from 1 to 0. The stored word becomes the old value ANDed with the written data.

Two bits of the lock word form a protection chain:

- Once the segment-lock bit is programmed, the four segment words can no longer change, and the security-lock bit can no longer be programmed.
- Once the security-lock bit is programmed, the block raises a permanent write-protect output. A neighbouring security region uses that output.

Any program aimed at a protected or unmapped location leaves the storage alone and sets a sticky error bit in the status byte.

The read port is combinational. It returns either the array (the segment words and the lock word) or the status byte, depending on the current read mode. Storage is not cleared by the functional reset. Only the preload input clears it, and that input stands in for the erased state of the cells.

Top module: `otp_prot_reg`

## Requirements
- R1: While `nv_preload` is high, every segment word is set to 0xFFFF and both lock bits are set to unprogrammed. Afterwards, in array mode, word addresses 0..3 and the lock address 0x80 read 0xFFFF, and `sec_wp` is 0.
- R2: A write of data[7:0]=0xC0 followed by a second write starts an operation. The status ready bit (bit 7) reads 0 for exactly 8 cycles after the second write, then reads 1.
- R3: A program to segment word k (address 0..3) leaves that word equal to its old value AND the written data. The other words are not touched.
- R4: After the setup write, and after the second write, reads return the status byte {8'h00, ready, 2'b00, error, 4'b0000}. Command 0x70 selects status mode and command 0xFF selects array mode.
- R5: When lock-word bit 1 is 0, any segment program leaves the segment unchanged and sets status bit 4.
- R6: When lock-word bit 1 is 0, a lock-word program with data bit 2 = 0 leaves the lock word unchanged and sets status bit 4.
- R7: Programming lock-word bit 2 to 0 drives `sec_wp` to 1. `sec_wp` stays at 1 across `rst_n`, until the next preload.
- R8: In a lock-word program, data bits other than 1 and 2 are ignored. The lock word reads as 0xFFFF with bit 1 and bit 2 replaced by the stored lock bits.
- R9: Every write made while an operation is busy is ignored, including 0xB0 (suspend) and a further 0xC0. The operation completes with its original address and data.
- R10: Asserting `rst_n` low during an operation aborts it. Storage stays unchanged, ready returns to 1 and the read mode becomes array. Stored values survive `rst_n`.
- R11: Status bit 4 stays set until command 0x50 clears it.
- R12: A program to an address that is neither 0..3 nor 0x80 changes nothing and sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the command logic and status |
| nv_preload | input | 1 | Returns the storage to its erased state (all ones, locks open) |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Word address of the bus write |
| wr_data | input | 16 | Command byte in bits 7:0, or program data |
| rd_addr | input | 8 | Word address for array reads |
| rd_data | output | 16 | Array word or status byte, by read mode |
| sec_wp | output | 1 | Permanent write protect for the security region |

## Verification
The hardest state to reach is the one where the segment-lock bit is programmed but the security-lock bit is still open. Getting there means programming the lock word in one order only. Any earlier lock-bit program would already have closed the path, so the stimulus preloads the storage a second time and then programs bit 1 alone before it tries bit 2. The abort case also needs care: the reset is placed three cycles into a busy window, so the pending program is dropped while the stored data must survive. A behavioural queue model, compared on every clock, follows these cases through.

// File: rtl/otp_pkg.sv
// Package: shared encodings for the one-time-programmable protection register.
package otp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BUSY  = 2'd2
    } cmd_state_e;

    typedef enum logic {
        RD_ARRAY  = 1'b0,
        RD_STATUS = 1'b1
    } rd_mode_e;

    localparam logic [7:0] OP_PROG_SETUP   = 8'hC0;
    localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;

    localparam int STAT_READY_BIT = 7;
    localparam int STAT_ERR_BIT   = 4;

    localparam int LK_SEG_BIT = 1;
    localparam int LK_SEC_BIT = 2;

endpackage

// File: rtl/otp_cmd.sv
// Module: otp_cmd
// Decodes bus writes into commands, holds the pending program operation,
// times the busy window and keeps the sticky error bit and the read mode.
// Assumes: PROG_CYCLES >= 2; reject is valid while the operation is busy
// and is sampled in the commit cycle.
module otp_cmd
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              reject,
    output logic              commit,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              ready,
    output logic              err,
    output rd_mode_e          rd_mode
);

    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

    cmd_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       opcode;
    logic             clr_cmd;

    assign opcode  = wr_data[7:0];
    assign clr_cmd = (state == ST_IDLE) && wr_en && (opcode == OP_CLEAR_STATUS);

    // Purpose: the last busy cycle hands the operation to storage.
    assign commit = rst_n && (state == ST_BUSY) && (cnt == '0);
    assign ready  = (state != ST_BUSY);

    // Purpose: command sequencing, busy timing, error and read-mode update.
    always_ff @(posedge clk) begin : seq_ctrl
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rd_mode <= RD_ARRAY;
            err     <= 1'b0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_en) begin
                        case (opcode)
                            OP_PROG_SETUP: begin
                                state   <= ST_SETUP;
                                rd_mode <= RD_STATUS;
                            end
                            OP_READ_STATUS:  rd_mode <= RD_STATUS;
                            OP_READ_ARRAY:   rd_mode <= RD_ARRAY;
                            OP_CLEAR_STATUS: err     <= 1'b0;
                            default: ;
                        endcase
                    end
                end
                ST_SETUP: begin
                    if (wr_en) begin
                        op_addr <= wr_addr;
                        op_data <= wr_data;
                        cnt     <= CNT_LOAD;
                        state   <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        if (reject) err <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && cnt != '0) |=> (state == ST_BUSY)); // R2

    AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ready && state == ST_IDLE)); // R2

    AST_BUSY_OPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |=> ($stable(op_addr) && $stable(op_data))); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_cmd) |=> err); // R11

endmodule

// File: rtl/otp_store.sv
// Module: otp_store
// Retained storage: the user segment words and the two lock bits.
// Decides whether the pending operation is rejected and applies accepted
// operations by ANDing, so bits can only fall. Assumes nv_preload is the
// only way back to the erased state; rst_n is used by assertions only.
module otp_store
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SEG_WORDS = 4,
    parameter int LOCK_ADDR = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        nv_preload,
    input  logic                        commit,
    input  logic [ADDR_W-1:0]           op_addr,
    input  logic [DATA_W-1:0]           op_data,
    output logic                        reject,
    output logic [SEG_WORDS*DATA_W-1:0] seg_flat,
    output logic                        lock_seg_n,
    output logic                        lock_sec_n
);

    localparam logic [ADDR_W-1:0] SEG_END = ADDR_W'(SEG_WORDS);
    localparam logic [ADDR_W-1:0] LK_ADDR = ADDR_W'(LOCK_ADDR);

    logic hit_seg;
    logic hit_lock;
    logic accept;

    // Purpose: classify the pending address and apply the protection chain.
    always_comb begin : chk_protect
        hit_seg  = (op_addr < SEG_END);
        hit_lock = (op_addr == LK_ADDR);
        if (hit_seg)       reject = !lock_seg_n;
        else if (hit_lock) reject = !lock_seg_n && !op_data[LK_SEC_BIT];
        else               reject = 1'b1;
    end

    assign accept = commit && !reject;

    for (genvar g = 0; g < SEG_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Purpose: erase on preload, otherwise clear the bits of an accepted program.
        always_ff @(posedge clk) begin : upd_word
            if (nv_preload)
                word_q <= '1;
            else if (accept && hit_seg && op_addr == ADDR_W'(g))
                word_q <= word_q & op_data;
        end

        assign seg_flat[g*DATA_W +: DATA_W] = word_q;
    end

    // Purpose: the two lock bits, open on preload, closed by an accepted lock program.
    always_ff @(posedge clk) begin : upd_lock
        if (nv_preload) begin
            lock_seg_n <= 1'b1;
            lock_sec_n <= 1'b1;
        end else if (accept && hit_lock) begin
            lock_seg_n <= lock_seg_n & op_data[LK_SEG_BIT];
            lock_sec_n <= lock_sec_n & op_data[LK_SEC_BIT];
        end
    end

    AST_SEG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || nv_preload)
        ((seg_flat & ~$past(seg_flat)) == '0)); // R3

    AST_LOCKED_SEG_STABLE: assert property (@(posedge clk) disable iff (!rst_n || nv_preload)
        (!lock_seg_n) |=> $stable(seg_flat)); // R5

    AST_BIT2_GUARDED: assert property (@(posedge clk) disable iff (!rst_n || nv_preload)
        (!lock_seg_n && lock_sec_n) |=> lock_sec_n); // R6

    AST_SEC_LOCK_PERMANENT: assert property (@(posedge clk) disable iff (nv_preload)
        (!lock_sec_n) |=> !lock_sec_n); // R7

endmodule

// File: rtl/otp_rdmux.sv
// Module: otp_rdmux
// Combinational read path: the status byte in status mode; otherwise a
// segment word, the lock word, or all ones for an unmapped address.
// Assumes ready, err and the storage are registered upstream.
module otp_rdmux
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SEG_WORDS = 4,
    parameter int LOCK_ADDR = 128
) (
    input  logic [ADDR_W-1:0]           rd_addr,
    input  rd_mode_e                    rd_mode,
    input  logic                        ready,
    input  logic                        err,
    input  logic [SEG_WORDS*DATA_W-1:0] seg_flat,
    input  logic                        lock_seg_n,
    input  logic                        lock_sec_n,
    output logic [DATA_W-1:0]           rd_data
);

    localparam logic [ADDR_W-1:0] LK_ADDR = ADDR_W'(LOCK_ADDR);

    logic [DATA_W-1:0] lock_word;
    logic [DATA_W-1:0] status_word;

    // Purpose: build the lock word and the status word.
    always_comb begin : build_words
        lock_word                 = '1;
        lock_word[LK_SEG_BIT]     = lock_seg_n;
        lock_word[LK_SEC_BIT]     = lock_sec_n;
        status_word               = '0;
        status_word[STAT_READY_BIT] = ready;
        status_word[STAT_ERR_BIT] = err;
    end

    // Purpose: select the word the read port returns.
    always_comb begin : sel_read
        if (rd_mode == RD_STATUS) begin
            rd_data = status_word;
        end else begin
            rd_data = '1;
            for (int i = 0; i < SEG_WORDS; i++)
                if (rd_addr == ADDR_W'(i)) rd_data = seg_flat[i*DATA_W +: DATA_W];
            if (rd_addr == LK_ADDR) rd_data = lock_word;
        end
    end

endmodule

// File: rtl/otp_prot_reg.sv
// Module: otp_prot_reg (top)
// One-time-programmable protection register: command decode, retained
// storage with a lock chain, and the read path. sec_wp tells a
// neighbouring security region that it is permanently write-protected.
// Assumes a synchronous active-low rst_n and a bench or power-on preload.
module otp_prot_reg
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SEG_WORDS   = 4,
    parameter int LOCK_ADDR   = 128,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_preload,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sec_wp
);

    logic                        commit;
    logic                        reject;
    logic [ADDR_W-1:0]           op_addr;
    logic [DATA_W-1:0]           op_data;
    logic                        ready;
    logic                        err;
    rd_mode_e                    rd_mode;
    logic [SEG_WORDS*DATA_W-1:0] seg_flat;
    logic                        lock_seg_n;
    logic                        lock_sec_n;

    otp_cmd #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
    ) i_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .reject(reject), .commit(commit),
        .op_addr(op_addr), .op_data(op_data), .ready(ready),
        .err(err), .rd_mode(rd_mode)
    );

    otp_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_WORDS(SEG_WORDS), .LOCK_ADDR(LOCK_ADDR)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .nv_preload(nv_preload), .commit(commit),
        .op_addr(op_addr), .op_data(op_data), .reject(reject),
        .seg_flat(seg_flat), .lock_seg_n(lock_seg_n), .lock_sec_n(lock_sec_n)
    );

    otp_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_WORDS(SEG_WORDS), .LOCK_ADDR(LOCK_ADDR)
    ) i_rdmux (
        .rd_addr(rd_addr), .rd_mode(rd_mode), .ready(ready), .err(err),
        .seg_flat(seg_flat), .lock_seg_n(lock_seg_n), .lock_sec_n(lock_sec_n),
        .rd_data(rd_data)
    );

    // Purpose: a programmed security-lock bit raises the region write protect.
    assign sec_wp = !lock_sec_n;

endmodule

// File: tb/test_otp_prot_reg.sv
module test_otp_prot_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_preload = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sec_wp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    string cur_req = "R1";

    // Reference model state
    logic [15:0] m_seg [4];
    bit m_p1, m_p2;
    bit m_setup, m_status, m_err;
    int cyc_no = 0;
    int q_due[$];
    logic [7:0]  q_addr[$];
    logic [15:0] q_data[$];

    always #10 clk = ~clk; // 50 MHz

    otp_prot_reg i_otp_prot_reg (
        .clk(clk), .rst_n(rst_n), .nv_preload(nv_preload), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_wp(sec_wp)
    );

    function automatic logic [15:0] m_read(input logic [7:0] a);
        if (m_status)
            return {8'h00, (q_due.size() == 0), 2'b00, m_err, 4'b0000};
        if (a < 8'd4) return m_seg[a[1:0]];
        if (a == 8'h80) return {13'h1FFF, !m_p2, !m_p1, 1'b1};
        return 16'hFFFF;
    endfunction

    task automatic m_apply(input logic [7:0] a, input logic [15:0] d);
        if (a < 8'd4) begin
            if (m_p1) m_err = 1;
            else m_seg[a[1:0]] = m_seg[a[1:0]] & d;
        end else if (a == 8'h80) begin
            if (m_p1 && !d[2]) m_err = 1;
            else begin
                if (!d[1]) m_p1 = 1;
                if (!d[2]) m_p2 = 1;
            end
        end else begin
            m_err = 1;
        end
    endtask

    task automatic model_step();
        cyc_no++;
        if (nv_preload) begin
            for (int i = 0; i < 4; i++) m_seg[i] = 16'hFFFF;
            m_p1 = 0;
            m_p2 = 0;
        end
        if (!rst_n) begin
            q_due.delete(); q_addr.delete(); q_data.delete();
            m_setup = 0; m_status = 0; m_err = 0;
            return;
        end
        if (q_due.size() != 0) begin
            if (q_due[0] == cyc_no) begin
                m_apply(q_addr[0], q_data[0]);
                void'(q_due.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
            end
            return;
        end
        if (wr_en) begin
            if (m_setup) begin
                q_due.push_back(cyc_no + 8);
                q_addr.push_back(wr_addr);
                q_data.push_back(wr_data);
                m_setup = 0;
                m_status = 1;
            end else begin
                case (wr_data[7:0])
                    8'hC0: begin m_setup = 1; m_status = 1; end
                    8'h70: m_status = 1;
                    8'hFF: m_status = 0;
                    8'h50: m_err = 0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(cur_req, rd_data, m_read(rd_addr));
        chk(cur_req, {15'b0, sec_wp}, {15'b0, m_p2});
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic prog(input logic [7:0] a, input logic [15:0] d);
        bus_wr(8'h00, 16'h00C0);
        bus_wr(a, d);
        repeat (8) cyc();
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [15:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic do_preload();
        rst_n = 0; nv_preload = 1;
        cyc(); cyc();
        nv_preload = 0;
        cyc();
        rst_n = 1;
        cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R2: watchdog expired, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        // R1: preload and reset state
        cur_req = "R1";
        do_preload();
        for (int i = 0; i < 4; i++) check_rd(8'(i), 16'hFFFF, "R1");
        check_rd(8'h80, 16'hFFFF, "R1");
        check_rd(8'h05, 16'hFFFF, "R1");
        chk("R1", {15'b0, sec_wp}, 16'h0000);

        // R2, R4: busy window and status reads
        cur_req = "R2";
        bus_wr(8'h00, 16'h00C0);
        check_rd(8'h01, 16'h0080, "R4");
        bus_wr(8'h01, 16'hF0F0);
        check_rd(8'h01, 16'h0000, "R2");
        repeat (7) cyc();
        check_rd(8'h01, 16'h0000, "R2");
        cyc();
        check_rd(8'h01, 16'h0080, "R2");
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h01, 16'hF0F0, "R3");
        check_rd(8'h00, 16'hFFFF, "R3");
        bus_wr(8'h00, 16'h0070);
        check_rd(8'h01, 16'h0080, "R4");

        // R3: second program ANDs into the word
        cur_req = "R3";
        prog(8'h01, 16'h3CFF);
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h01, 16'h30F0, "R3");
        check_rd(8'h02, 16'hFFFF, "R3");

        // R12, R11: unmapped address, sticky error, clear
        cur_req = "R12";
        prog(8'h09, 16'h0000);
        check_rd(8'h00, 16'h0090, "R12");
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h00, 16'hFFFF, "R12");
        check_rd(8'h09, 16'hFFFF, "R12");
        cur_req = "R11";
        bus_wr(8'h00, 16'h0070);
        check_rd(8'h00, 16'h0090, "R11");
        bus_wr(8'h00, 16'h0050);
        check_rd(8'h00, 16'h0080, "R11");

        // R8: lock-word bits other than 1 and 2 are ignored
        cur_req = "R8";
        prog(8'h80, 16'h0006);
        check_rd(8'h80, 16'h0080, "R8");
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h80, 16'hFFFF, "R8");
        chk("R8", {15'b0, sec_wp}, 16'h0000);

        // R10: reset during busy aborts the operation
        cur_req = "R10";
        bus_wr(8'h00, 16'h00C0);
        bus_wr(8'h02, 16'h0000);
        repeat (3) cyc();
        rst_n = 0;
        cyc();
        rst_n = 1;
        check_rd(8'h02, 16'hFFFF, "R10");
        check_rd(8'h01, 16'h30F0, "R10");
        cyc();
        bus_wr(8'h00, 16'h0070);
        check_rd(8'h00, 16'h0080, "R10");

        // R9: writes while busy are ignored
        cur_req = "R9";
        bus_wr(8'h00, 16'h00C0);
        bus_wr(8'h03, 16'h00FF);
        bus_wr(8'h00, 16'h00B0);
        bus_wr(8'h00, 16'h00C0);
        bus_wr(8'h03, 16'h0000);
        repeat (5) cyc();
        check_rd(8'h03, 16'h0080, "R9");
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h03, 16'h00FF, "R9");

        // R7: security lock raises sec_wp and survives rst_n
        cur_req = "R7";
        prog(8'h80, 16'hFFFB);
        chk("R7", {15'b0, sec_wp}, 16'h0001);
        rst_n = 0;
        cyc();
        rst_n = 1;
        cyc();
        chk("R7", {15'b0, sec_wp}, 16'h0001);
        check_rd(8'h80, 16'hFFFB, "R7");

        // R5: segment lock blocks segment programs
        cur_req = "R5";
        prog(8'h80, 16'hFFFD);
        check_rd(8'h00, 16'h0080, "R5");
        prog(8'h00, 16'h0000);
        check_rd(8'h00, 16'h0090, "R5");
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h00, 16'hFFFF, "R5");
        check_rd(8'h80, 16'hFFF9, "R5");
        bus_wr(8'h00, 16'h0050);

        // R6: segment lock guards the security lock bit
        cur_req = "R6";
        do_preload();
        chk("R6", {15'b0, sec_wp}, 16'h0000);
        check_rd(8'h03, 16'hFFFF, "R1");
        prog(8'h80, 16'hFFFD);
        prog(8'h80, 16'hFFFB);
        check_rd(8'h80, 16'h0090, "R6");
        bus_wr(8'h00, 16'h00FF);
        check_rd(8'h80, 16'hFFFD, "R6");
        chk("R6", {15'b0, sec_wp}, 16'h0000);
        cyc();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule